// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Gated Status

This block receives asynchronous serial frames on an idle-high line. It uses a 16x oversampling enable to find a start bit and confirm it at mid-bit. It then samples each following bit at its centre, collects the data bits into a shift register, and checks parity and the stop bit. A frame that passes every check goes into an 8-bit holding register and raises a data-full flag.

A frame that fails a check raises an error flag instead. Overrun, framing and parity errors are flagged separately. While any error flag is up, the receiver will not start a new frame.

Software clears the flags through a one-strobe register port. Writing a 0 to a flag's bit clears that flag. Writing a 1 leaves it unchanged. One enable gates both the data-full interrupt request and the error interrupt request.

The configuration pins are captured at each start bit. They select a data length of 7 or 8 bits, parity on or off, even or odd parity, and one or two stop bits.

Top module: `srx_top`

## Requirements
- R1: A low level seen on the line while idle is accepted as a start bit only if the line is still low 8 oversample ticks later. Otherwise the receiver returns to idle, and no flag or data changes.
- R2: Data bits are taken least significant bit first, and each bit is sampled at its centre, 16 ticks after the previous sample. In 8-bit mode, all 8 bits appear in `rx_data`.
- R3: When `cfg_len7`=1, seven data bits are received and stored zero-extended, so `rx_data[7]`=0.
- R4: When `cfg_par_en`=1, one parity bit follows the data. Parity holds when the number of ones in the data bits plus the parity bit is even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1); a mismatch sets `err_parity`. When `cfg_par_en`=0, no parity bit is expected and `err_parity` is never set.
- R5: A first stop bit sampled as 0 sets `err_frame`. When `cfg_stop2`=1, the second stop bit is not checked, and a low level in it neither raises a flag nor starts a frame.
- R6: A frame that passes every check, completing while `rx_full`=0, is written to `rx_data` and sets `rx_full`.
- R7: A frame that completes while `rx_full`=1 sets `err_overrun` and is discarded: `rx_data` and `rx_full` keep their values.
- R8: A frame with a framing or parity error, completing while `rx_full`=0, is still written to `rx_data`, but `rx_full` stays 0.
- R9: While any of `err_overrun`, `err_frame` or `err_parity` is 1, no new frame is started. Reception resumes once all three are cleared.
- R10: `irq_rxi` = `rie` AND `rx_full`. `irq_eri` = `rie` AND (any error flag).
- R11: On a cycle with `clr_we`=1, each flag whose `clr_data` bit is 0 is cleared. Bit 0 is `rx_full`, bit 1 is `err_overrun`, bit 2 is `err_frame` and bit 3 is `err_parity`; a 1 bit leaves its flag unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R12: After reset, all flags are 0, `rx_data` is 0 and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, one pulse per 1/16 bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | 1: parity bit present and checked |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits |
| rie | input | 1 | Receive interrupt enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_data | input | 4 | Write-zero clear mask for the flags |
| rx_data | output | 8 | Receive holding register |
| rx_full | output | 1 | Data-full flag |
| err_overrun | output | 1 | Overrun error flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| irq_rxi | output | 1 | Receive-data-full interrupt request |
| irq_eri | output | 1 | Receive-error interrupt request |

## Verification
Each faulty internal state shows at the ports in a different way and within a bounded time:
- A sample counter that drifts or a wrong bit index shows as wrong or shifted bits in `rx_data` at the end of the same frame.
- A wrong parity accumulator or stop-bit decision shows as a wrong error flag two clocks after the stop-bit centre.
- A blocking condition that is stuck, or missing, shows on the next frame as a missing or unexpected change of `rx_data` and `rx_full`.
- A false start that is not rejected shows as a spurious frame or flag about one frame time later.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } rx_cfg_t;

  localparam int unsigned FLAG_FULL = 0;
  localparam int unsigned FLAG_OVR  = 1;
  localparam int unsigned FLAG_FRM  = 2;
  localparam int unsigned FLAG_PAR  = 3;
  localparam int unsigned NUM_FLAGS = 4;

endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  rx_cfg_t           cfg,
  input  logic              blocked,
  output logic              done,
  output logic [DATA_W-1:0] frame_data,
  output logic              stop_bad,
  output logic              par_bad,
  output logic              active
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CONE_C = CNT_W'(1);
  localparam logic [IDX_W-1:0] IONE_C = IDX_W'(1);
  localparam logic [IDX_W-1:0] FULL_LAST_C  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] SHORT_LAST_C = IDX_W'(DATA_W - 2);

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              acc_q, acc_d;
  rx_cfg_t           cfg_q, cfg_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              sbad_q, sbad_d;
  logic              pbad_q, pbad_d;
  logic [IDX_W-1:0]  last_idx;
  logic              at_mid, at_last;

  assign last_idx = cfg_q.len7 ? SHORT_LAST_C : FULL_LAST_C;
  assign at_mid   = (cnt_q == MID_C);
  assign at_last  = (cnt_q == LAST_C);

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    acc_d  = acc_q;
    cfg_d  = cfg_q;
    done_d = 1'b0;
    dout_d = dout_q;
    sbad_d = sbad_q;
    pbad_d = pbad_q;
    if (tick) begin
      case (st_q)
        ST_IDLE: begin
          if (!line && !blocked) begin
            st_d  = ST_START;
            cnt_d = '0;
            cfg_d = cfg;
          end
        end
        ST_START: begin
          if (at_mid) begin
            if (!line) begin
              st_d   = ST_DATA;
              cnt_d  = '0;
              idx_d  = '0;
              sh_d   = '0;
              acc_d  = 1'b0;
              pbad_d = 1'b0;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CONE_C;
          end
        end
        ST_DATA: begin
          if (at_last) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[DATA_W-1:1]};
            acc_d = acc_q ^ line;
            if (idx_q == last_idx) begin
              st_d = cfg_q.par_en ? ST_PAR : ST_STOP;
            end else begin
              idx_d = idx_q + IONE_C;
            end
          end else begin
            cnt_d = cnt_q + CONE_C;
          end
        end
        ST_PAR: begin
          if (at_last) begin
            cnt_d  = '0;
            pbad_d = acc_q ^ line ^ cfg_q.par_odd;
            st_d   = ST_STOP;
          end else begin
            cnt_d = cnt_q + CONE_C;
          end
        end
        ST_STOP: begin
          if (at_last) begin
            cnt_d  = '0;
            done_d = 1'b1;
            sbad_d = ~line;
            dout_d = cfg_q.len7 ? {1'b0, sh_q[DATA_W-1:1]} : sh_q;
            st_d   = cfg_q.stop2 ? ST_STOP2 : ST_IDLE;
          end else begin
            cnt_d = cnt_q + CONE_C;
          end
        end
        ST_STOP2: begin
          if (at_last) begin
            cnt_d = '0;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CONE_C;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      acc_q  <= 1'b0;
      cfg_q  <= '0;
      done_q <= 1'b0;
      dout_q <= '0;
      sbad_q <= 1'b0;
      pbad_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      acc_q  <= acc_d;
      cfg_q  <= cfg_d;
      done_q <= done_d;
      dout_q <= dout_d;
      sbad_q <= sbad_d;
      pbad_q <= pbad_d;
    end
  end

  assign done       = done_q;
  assign frame_data = dout_q;
  assign stop_bad   = sbad_q;
  assign par_bad    = pbad_q;
  assign active     = (st_q != ST_IDLE);
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_W-1:0]    frame_data,
  input  logic                 stop_bad,
  input  logic                 par_bad,
  input  logic                 clr_we,
  input  logic [NUM_FLAGS-1:0] clr_data,
  input  logic                 rie,
  output logic [DATA_W-1:0]    hold_data,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq_rxi,
  output logic                 irq_eri,
  output logic                 blocked
);
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_q, flag_d;
  logic [DATA_W-1:0]    hold_q, hold_d;
  logic                 full_now;
  logic                 load;

  assign full_now = flag_q[FLAG_FULL];
  assign load     = done && !full_now;

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_FULL] = load && !stop_bad && !par_bad;
    set_vec[FLAG_OVR]  = done && full_now;
    set_vec[FLAG_FRM]  = done && stop_bad;
    set_vec[FLAG_PAR]  = done && par_bad;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (clr_we && !clr_data[i]) flag_d[i] = 1'b0;
      if (set_vec[i])             flag_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = frame_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hold_data = hold_q;
  assign flags     = flag_q;
  assign blocked   = flag_q[FLAG_OVR] | flag_q[FLAG_FRM] | flag_q[FLAG_PAR];
  assign irq_rxi   = rie & flag_q[FLAG_FULL];
  assign irq_eri   = rie & blocked;
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              rie,
  input  logic              clr_we,
  input  logic [3:0]        clr_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_parity,
  output logic              irq_rxi,
  output logic              irq_eri
);
  logic                 rst_n_int;
  logic                 line_s;
  logic                 blocked;
  logic                 done;
  logic [DATA_W-1:0]    frame_data;
  logic                 stop_bad;
  logic                 par_bad;
  logic                 fr_active;
  logic [NUM_FLAGS-1:0] flags;
  rx_cfg_t              cfg;

  assign cfg = '{len7: cfg_len7, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};

  srx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .din(rxd), .dout(line_s)
  );

  srx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n_int), .tick(os_tick), .line(line_s), .cfg(cfg),
    .blocked(blocked), .done(done), .frame_data(frame_data),
    .stop_bad(stop_bad), .par_bad(par_bad), .active(fr_active)
  );

  srx_status #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n_int), .done(done), .frame_data(frame_data),
    .stop_bad(stop_bad), .par_bad(par_bad), .clr_we(clr_we), .clr_data(clr_data),
    .rie(rie), .hold_data(rx_data), .flags(flags), .irq_rxi(irq_rxi),
    .irq_eri(irq_eri), .blocked(blocked)
  );

  assign rx_full     = flags[FLAG_FULL];
  assign err_overrun = flags[FLAG_OVR];
  assign err_frame   = flags[FLAG_FRM];
  assign err_parity  = flags[FLAG_PAR];
endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rie,
  input logic              clr_we,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              err_overrun,
  input logic              err_frame,
  input logic              err_parity,
  input logic              irq_rxi,
  input logic              irq_eri,
  input logic              fr_active
);
  logic any_err;
  assign any_err = err_overrun | err_frame | err_parity;

  AST_FULL_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !any_err); // R6

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $stable(rx_data)); // R7

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_full)); // R7

  AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!fr_active && any_err) |=> !fr_active); // R9

  AST_RXI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rxi) |-> ($rose(rx_full) || $rose(rie))); // R10

  AST_ERI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_eri) |-> (!rie || $past(clr_we))); // R10
endmodule

bind srx_top srx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rie(rie), .clr_we(clr_we), .rx_data(rx_data),
  .rx_full(rx_full), .err_overrun(err_overrun), .err_frame(err_frame),
  .err_parity(err_parity), .irq_rxi(irq_rxi), .irq_eri(irq_eri),
  .fr_active(fr_active)
);

// File: tb/srx_top_test.sv
module srx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int OSR        = 16;
  localparam int BIT_CLKS   = TDIV * OSR;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic       cfg_len7, cfg_par_en, cfg_par_odd, cfg_stop2;
  logic       rie;
  logic       clr_we;
  logic [3:0] clr_data;
  logic [7:0] rx_data;
  logic       rx_full, err_overrun, err_frame, err_parity, irq_rxi, irq_eri;

  int checks = 0;
  int fails  = 0;
  int mon_cnt = 0;
  bit mon_en = 1'b0;

  srx_top uut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .rie(rie), .clr_we(clr_we), .clr_data(clr_data),
    .rx_data(rx_data), .rx_full(rx_full), .err_overrun(err_overrun),
    .err_frame(err_frame), .err_parity(err_parity), .irq_rxi(irq_rxi),
    .irq_eri(irq_eri)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    os_tick = 1'b0;
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && err_parity) mon_cnt++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input bit l7, input bit pe, input bit odd, input bit s2);
    cfg_len7 = l7; cfg_par_en = pe; cfg_par_odd = odd; cfg_stop2 = s2;
  endtask

  task automatic line_bit(input bit b);
    @(negedge clk);
    rxd = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  function automatic bit par_of(input logic [7:0] d, input int nb, input bit odd);
    bit p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pe,
                            input bit pbit, input bit s1, input bit two, input bit s2);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (pe) line_bit(pbit);
    line_bit(s1);
    if (two) line_bit(s2);
    @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
  endtask

  task automatic clear(input logic [3:0] v);
    @(negedge clk);
    clr_we = 1'b1; clr_data = v;
    @(negedge clk);
    clr_we = 1'b0; clr_data = 4'hF;
  endtask

  task automatic expect_flags(input string req, input bit f, input bit o,
                              input bit fr, input bit p);
    check(req, "rx_full", rx_full, f);
    check(req, "err_overrun", err_overrun, o);
    check(req, "err_frame", err_frame, fr);
    check(req, "err_parity", err_parity, p);
  endtask

  task automatic t_reset;
    expect_flags("R12", 0, 0, 0, 0);
    check("R12", "rx_data", rx_data, 8'h00);
    check("R12", "irq_rxi", irq_rxi, 0);
    check("R12", "irq_eri", irq_eri, 0);
  endtask

  task automatic t_basic;
    set_cfg(0, 0, 0, 0);
    rie = 1'b1;
    send_frame(8'hA5, 8, 0, 0, 1, 0, 1);
    check("R2", "rx_data lsb first", rx_data, 8'hA5);
    expect_flags("R6", 1, 0, 0, 0);
    check("R10", "irq_rxi", irq_rxi, 1);
    check("R10", "irq_eri", irq_eri, 0);
    @(negedge clk); rie = 1'b0; @(negedge clk);
    check("R10", "irq_rxi gated", irq_rxi, 0);
    rie = 1'b1;
    clear(4'b1110);
    check("R11", "rx_full cleared", rx_full, 0);
    check("R11", "data kept", rx_data, 8'hA5);
    check("R10", "irq_rxi after clear", irq_rxi, 0);
  endtask

  task automatic t_seven;
    set_cfg(1, 1, 0, 0);
    send_frame(8'hD3, 7, 1, par_of(8'hD3, 7, 0), 1, 0, 1);
    check("R3", "rx_data 7-bit", rx_data, 8'h53);
    expect_flags("R3", 1, 0, 0, 0);
    clear(4'b1110);
  endtask

  task automatic t_parity_block;
    set_cfg(0, 1, 1, 0);
    send_frame(8'h3C, 8, 1, par_of(8'h3C, 8, 1), 1, 0, 1);
    check("R4", "good odd parity data", rx_data, 8'h3C);
    expect_flags("R4", 1, 0, 0, 0);
    clear(4'b1110);
    send_frame(8'h81, 8, 1, ~par_of(8'h81, 8, 1), 1, 0, 1);
    expect_flags("R4", 0, 0, 0, 1);
    check("R8", "parity-error data stored", rx_data, 8'h81);
    check("R10", "irq_eri", irq_eri, 1);
    send_frame(8'h11, 8, 1, par_of(8'h11, 8, 1), 1, 0, 1);
    check("R9", "blocked data", rx_data, 8'h81);
    expect_flags("R9", 0, 0, 0, 1);
    clear(4'b0111);
    check("R11", "err_parity cleared", err_parity, 0);
    send_frame(8'h22, 8, 1, par_of(8'h22, 8, 1), 1, 0, 1);
    check("R9", "resumed data", rx_data, 8'h22);
    check("R9", "resumed full", rx_full, 1);
    clear(4'b1110);
  endtask

  task automatic t_false_start;
    set_cfg(0, 0, 0, 0);
    @(negedge clk); rxd = 1'b0;
    repeat (5 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    expect_flags("R1", 0, 0, 0, 0);
    check("R1", "data unchanged", rx_data, 8'h22);
    send_frame(8'h96, 8, 0, 0, 1, 0, 1);
    check("R1", "next frame ok", rx_data, 8'h96);
    clear(4'b1110);
  endtask

  task automatic t_framing;
    set_cfg(0, 0, 0, 0);
    send_frame(8'h4B, 8, 0, 0, 0, 0, 1);
    expect_flags("R5", 0, 0, 1, 0);
    check("R8", "framing-error data stored", rx_data, 8'h4B);
    clear(4'b1011);
    set_cfg(0, 0, 0, 1);
    send_frame(8'hE7, 8, 0, 0, 1, 1, 0);
    expect_flags("R5", 1, 0, 0, 0);
    check("R5", "second stop ignored data", rx_data, 8'hE7);
    clear(4'b1110);
    send_frame(8'h3A, 8, 0, 0, 0, 1, 1);
    check("R5", "first stop checked", err_frame, 1);
    clear(4'b0000);
  endtask

  task automatic t_overrun;
    set_cfg(0, 0, 0, 0);
    send_frame(8'h5A, 8, 0, 0, 1, 0, 1);
    check("R6", "first data", rx_data, 8'h5A);
    send_frame(8'hC3, 8, 0, 0, 1, 0, 1);
    expect_flags("R7", 1, 1, 0, 0);
    check("R7", "data kept", rx_data, 8'h5A);
    check("R10", "irq_eri overrun", irq_eri, 1);
    clear(4'b1111);
    check("R11", "write ones keeps overrun", err_overrun, 1);
    clear(4'b0000);
    expect_flags("R11", 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    set_cfg(0, 1, 0, 0);
    mon_cnt = 0;
    @(negedge clk);
    clr_we = 1'b1; clr_data = 4'b0111; mon_en = 1'b1;
    send_frame(8'h0F, 8, 1, ~par_of(8'h0F, 8, 0), 1, 0, 1);
    mon_en = 1'b0; clr_we = 1'b0; clr_data = 4'hF;
    check("R11", "set beats clear cycles", mon_cnt, 1);
    check("R11", "err_parity after held clear", err_parity, 0);
    check("R8", "data stored", rx_data, 8'h0F);
  endtask

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rie = 1'b0; clr_we = 1'b0; clr_data = 4'hF;
    set_cfg(0, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_seven();
    t_parity_block();
    t_false_start();
    t_framing();
    t_overrun();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule